// File: doc/BRIEF.md
# Cartridge ROM Read Cache

This block sits between an emulated cartridge bus and a 64-bit memory read/write initiator that reaches a ROM image kept in shared system memory. The emulated core asks for one byte at a time. When the 8-byte line holding that byte is present, the byte comes back in the next cycle. When it is absent, the block issues a single, unpipelined 64-bit read, returns the byte and installs the line. During the fetch it holds a stall output high, so the core is never handed late or corrupt data.

Writes aimed at battery-backed save memory always go through to system memory as a single-byte strobed word write. A write that hits a resident line also updates that byte in the cache, so later reads see the new value.

The ROM image starts at a programmable physical base address. A flush input empties the cache in one cycle. Any change of the base address has the same effect. Three counters report read hits, read misses and stalled cycles for tuning.

Top module: `cart_cache`

## Requirements
- R1: After reset, stall, cart_rvalid and mem_req are low, all three counters are zero and every line is invalid.
- R2: A read whose line is valid with a matching tag returns the byte on cart_rdata with cart_rvalid high in the cycle after the request. Stall stays low and no memory transaction is made.
- R3: A read that misses raises stall from the cycle after the request. It raises mem_req with mem_we low and mem_addr equal to base_addr plus the cart address with bits 2:0 cleared, and holds mem_req and mem_addr steady until mem_ack. In the cycle after mem_ack, stall falls and the byte comes back with cart_rvalid. The line is then valid.
- R4: Cart address bits 2:0 pick byte lane k, which is mem_rdata[8k+7:8k]. Bits 11:3 select one of 512 lines and the remaining upper bits form the tag. Two addresses with the same index and different tags displace each other.
- R5: Every write raises stall and makes one memory transaction with mem_we high. mem_addr is the aligned word address, mem_wstrb has only bit k set for byte offset k, and the written byte appears in all eight lanes of mem_wdata. Stall falls in the cycle after mem_ack and cart_rvalid stays low.
- R6: A write whose line is resident updates the cached byte, so a following read hits and returns the new value. A write that misses allocates no line.
- R7: A flush pulse invalidates every line. A request made in the same cycle as a flush is treated as a miss.
- R8: A change of base_addr invalidates every line, and later fetches use the new base.
- R9: A flush that arrives while a fetch is outstanding, including in the cycle of mem_ack, still returns the fetched byte but leaves the line invalid.
- R10: hit_count rises by one per read hit and miss_count by one per read miss; writes change neither. stall_count rises by one for each cycle in which stall is high.
- R11: A request presented while stall is high is ignored: it starts no memory transaction, changes no counter and does not alter the byte returned for the pending read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_addr | input | PHYS_W | Physical base of the ROM image |
| flush | input | 1 | Invalidate all lines |
| cart_req | input | 1 | Core request strobe, taken while stall is low |
| cart_we | input | 1 | Request is a write |
| cart_addr | input | ADDR_W | Byte offset into the image |
| cart_wdata | input | 8 | Write byte |
| cart_rdata | output | 8 | Read byte |
| cart_rvalid | output | 1 | Read byte valid |
| stall | output | 1 | Core must wait |
| mem_req | output | 1 | Memory transaction request |
| mem_we | output | 1 | Memory transaction is a write |
| mem_addr | output | PHYS_W | Aligned physical word address |
| mem_wdata | output | 64 | Write word |
| mem_wstrb | output | 8 | Write byte strobes |
| mem_ack | input | 1 | Transaction complete, read data valid |
| mem_rdata | input | 64 | Read word |
| hit_count | output | CNT_W | Read hit counter |
| miss_count | output | CNT_W | Read miss counter |
| stall_count | output | CNT_W | Stalled cycle counter |

## Verification
An invalidation (a flush pulse or a base change) can land in the same cycle as a line fill completing, or in the same cycle as a fresh lookup. The bench makes the memory responder raise flush together with mem_ack. It also drives flush alongside a request for a resident line and changes the base between accesses. It then judges the outcome at the ports: the fetched byte must still come back, the next read of that line must miss and fetch again from the current base, and the hit and miss counters must match the bench's own tally.

// File: rtl/cc_pkg.sv
package cc_pkg;
   typedef enum logic [1:0] {
      CC_IDLE  = 2'd0,
      CC_FILL  = 2'd1,
      CC_WRITE = 2'd2
   } cc_state_e;
endpackage

// File: rtl/cc_tag_store.sv
module cc_tag_store #(
   parameter int LINES = 512,
   parameter int TAG_W = 11,
   localparam int IDX_W = $clog2(LINES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic [IDX_W-1:0] look_idx,
   input  logic [TAG_W-1:0] look_tag,
   output logic             look_hit,
   input  logic             fill_en,
   input  logic [IDX_W-1:0] fill_idx,
   input  logic [TAG_W-1:0] fill_tag
);
   logic [LINES-1:0] valid_q;
   logic [TAG_W-1:0] tag_q [LINES];

   assign look_hit = valid_q[look_idx] && (tag_q[look_idx] == look_tag);

   always_ff @(posedge clk) begin
      if (!rst_n)
         valid_q <= '0;
      else if (clr)
         valid_q <= '0;
      else if (fill_en)
         valid_q[fill_idx] <= 1'b1;
   end

   always_ff @(posedge clk) begin
      if (fill_en && !clr)
         tag_q[fill_idx] <= fill_tag;
   end

   assert_clear_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (valid_q == '0));

   assert_fill_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_en && !clr) |=> valid_q[$past(fill_idx)]);
endmodule

// File: rtl/cc_data_store.sv
module cc_data_store #(
   parameter int LINES = 512,
   parameter int LANES = 8,
   localparam int IDX_W = $clog2(LINES),
   localparam int OFF_W = $clog2(LANES)
) (
   input  logic               clk,
   input  logic [IDX_W-1:0]   rd_idx,
   input  logic [OFF_W-1:0]   rd_off,
   output logic [7:0]         rd_byte,
   input  logic               fill_en,
   input  logic [IDX_W-1:0]   fill_idx,
   input  logic [8*LANES-1:0] fill_data,
   input  logic               wr_en,
   input  logic [IDX_W-1:0]   wr_idx,
   input  logic [OFF_W-1:0]   wr_off,
   input  logic [7:0]         wr_byte
);
   logic [LANES-1:0][7:0] lane_rd;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [7:0] lane_q [LINES];
      always_ff @(posedge clk) begin
         if (fill_en)
            lane_q[fill_idx] <= fill_data[8*g +: 8];
         else if (wr_en && (wr_off == OFF_W'(g)))
            lane_q[wr_idx] <= wr_byte;
      end
      assign lane_rd[g] = lane_q[rd_idx];
   end

   assign rd_byte = lane_rd[rd_off];
endmodule

// File: rtl/cc_counters.sv
module cc_counters #(
   parameter int NUM   = 3,
   parameter int CNT_W = 32
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NUM-1:0]            inc,
   output logic [NUM-1:0][CNT_W-1:0] cnt
);
   for (genvar g = 0; g < NUM; g++) begin : g_cnt
      always_ff @(posedge clk) begin
         if (!rst_n)
            cnt[g] <= '0;
         else if (inc[g])
            cnt[g] <= cnt[g] + CNT_W'(1);
      end

      assert_count_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
         inc[g] |=> (cnt[g] == $past(cnt[g]) + CNT_W'(1)));

      assert_count_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
         !inc[g] |=> $stable(cnt[g]));
   end
endmodule

// File: rtl/cart_cache.sv
module cart_cache
   import cc_pkg::*;
#(
   parameter int ADDR_W = 23,
   parameter int PHYS_W = 32,
   parameter int LINES  = 512,
   parameter int CNT_W  = 32,
   parameter int BUS_W  = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PHYS_W-1:0] base_addr,
   input  logic              flush,
   input  logic              cart_req,
   input  logic              cart_we,
   input  logic [ADDR_W-1:0] cart_addr,
   input  logic [7:0]        cart_wdata,
   output logic [7:0]        cart_rdata,
   output logic              cart_rvalid,
   output logic              stall,
   output logic              mem_req,
   output logic              mem_we,
   output logic [PHYS_W-1:0] mem_addr,
   output logic [BUS_W-1:0]  mem_wdata,
   output logic [BUS_W/8-1:0] mem_wstrb,
   input  logic              mem_ack,
   input  logic [BUS_W-1:0]  mem_rdata,
   output logic [CNT_W-1:0]  hit_count,
   output logic [CNT_W-1:0]  miss_count,
   output logic [CNT_W-1:0]  stall_count
);
   localparam int LANES = BUS_W / 8;
   localparam int OFF_W = $clog2(LANES);
   localparam int IDX_W = $clog2(LINES);
   localparam int TAG_W = ADDR_W - IDX_W - OFF_W;

   if (BUS_W != 64) begin : g_bad_bus
      $error("cart_cache: line and bus width are fixed at 64 bits");
   end
   if (LINES < 2 || LINES != (1 << IDX_W)) begin : g_bad_lines
      $error("cart_cache: LINES must be a power of two");
   end
   if (TAG_W < 1 || ADDR_W > PHYS_W) begin : g_bad_addr
      $error("cart_cache: address widths leave no tag or exceed the bus");
   end

   cc_state_e         state_q;
   logic [ADDR_W-1:0] addr_q;
   logic [PHYS_W-1:0] paddr_q, base_q, req_paddr;
   logic [7:0]        wbyte_q, rdata_q, store_byte, fill_byte;
   logic              rvalid_q, stale_q;
   logic              flush_now, look_hit, hit, idle;
   logic              rd_hit, rd_miss, wr_hit, fill_en;
   logic [BUS_W-1:0]  rd_shift;

   assign idle      = (state_q == CC_IDLE);
   assign flush_now = flush || (base_addr != base_q);
   assign hit       = look_hit && !flush_now;
   assign rd_hit    = idle && cart_req && !cart_we && hit;
   assign rd_miss   = idle && cart_req && !cart_we && !hit;
   assign wr_hit    = idle && cart_req && cart_we && hit;
   assign fill_en   = (state_q == CC_FILL) && mem_ack && !stale_q && !flush_now;
   assign req_paddr = base_addr + PHYS_W'({cart_addr[ADDR_W-1:OFF_W], OFF_W'(0)});
   assign rd_shift  = mem_rdata >> {addr_q[OFF_W-1:0], 3'b000};
   assign fill_byte = rd_shift[7:0];

   cc_tag_store #(.LINES(LINES), .TAG_W(TAG_W)) u_tags (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (flush_now),
      .look_idx (cart_addr[OFF_W +: IDX_W]),
      .look_tag (cart_addr[ADDR_W-1 -: TAG_W]),
      .look_hit (look_hit),
      .fill_en  (fill_en),
      .fill_idx (addr_q[OFF_W +: IDX_W]),
      .fill_tag (addr_q[ADDR_W-1 -: TAG_W])
   );

   cc_data_store #(.LINES(LINES), .LANES(LANES)) u_data (
      .clk       (clk),
      .rd_idx    (cart_addr[OFF_W +: IDX_W]),
      .rd_off    (cart_addr[OFF_W-1:0]),
      .rd_byte   (store_byte),
      .fill_en   (fill_en),
      .fill_idx  (addr_q[OFF_W +: IDX_W]),
      .fill_data (mem_rdata),
      .wr_en     (wr_hit),
      .wr_idx    (cart_addr[OFF_W +: IDX_W]),
      .wr_off    (cart_addr[OFF_W-1:0]),
      .wr_byte   (cart_wdata)
   );

   logic [2:0][CNT_W-1:0] cnt;
   cc_counters #(.NUM(3), .CNT_W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   ({stall, rd_miss, rd_hit}),
      .cnt   (cnt)
   );
   assign hit_count   = cnt[0];
   assign miss_count  = cnt[1];
   assign stall_count = cnt[2];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= CC_IDLE;
         addr_q   <= '0;
         paddr_q  <= '0;
         base_q   <= '0;
         wbyte_q  <= '0;
         rdata_q  <= '0;
         rvalid_q <= 1'b0;
         stale_q  <= 1'b0;
      end else begin
         base_q   <= base_addr;
         rvalid_q <= 1'b0;
         case (state_q)
            CC_IDLE: begin
               if (cart_req) begin
                  addr_q  <= cart_addr;
                  paddr_q <= req_paddr;
                  wbyte_q <= cart_wdata;
                  stale_q <= 1'b0;
                  if (cart_we) begin
                     state_q <= CC_WRITE;
                  end else if (hit) begin
                     rvalid_q <= 1'b1;
                     rdata_q  <= store_byte;
                  end else begin
                     state_q <= CC_FILL;
                  end
               end
            end
            CC_FILL: begin
               if (flush_now)
                  stale_q <= 1'b1;
               if (mem_ack) begin
                  state_q  <= CC_IDLE;
                  rvalid_q <= 1'b1;
                  rdata_q  <= fill_byte;
               end
            end
            CC_WRITE: begin
               if (mem_ack)
                  state_q <= CC_IDLE;
            end
            default: state_q <= CC_IDLE;
         endcase
      end
   end

   assign stall       = !idle;
   assign cart_rvalid = rvalid_q;
   assign cart_rdata  = rdata_q;
   assign mem_req     = !idle;
   assign mem_we      = (state_q == CC_WRITE);
   assign mem_addr    = paddr_q;
   assign mem_wdata   = {LANES{wbyte_q}};
   assign mem_wstrb   = (state_q == CC_WRITE) ? (LANES'(1) << addr_q[OFF_W-1:0]) : '0;

   assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

   assert_miss_stalls_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cart_req && !stall && !cart_we && !hit) |=> (stall && mem_req && !mem_we));

   assert_rvalid_free_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cart_rvalid |-> !stall);

   assert_strobe_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |-> ($countones(mem_wstrb) == 1));

   assert_read_nostrobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_we) |-> (mem_wstrb == '0));

   assert_busy_ignores_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (stall && !mem_ack) |=> $stable(mem_addr));
endmodule

// File: tb/sim_cart_cache.sv
`timescale 1ns/1ps
module sim_cart_cache;
   logic        clk = 0;
   logic        rst_n = 0;
   logic [31:0] base_addr = 32'h1000_0000;
   logic        flush_drv = 0, ack_flush = 0;
   logic        cart_req = 0, cart_we = 0;
   logic [22:0] cart_addr = '0;
   logic [7:0]  cart_wdata = '0;
   logic [7:0]  cart_rdata;
   logic        cart_rvalid, stall, mem_req, mem_we;
   logic [31:0] mem_addr;
   logic [63:0] mem_wdata;
   logic [7:0]  mem_wstrb;
   logic        mem_ack = 0;
   logic [63:0] mem_rdata = '0;
   logic [31:0] hit_count, miss_count, stall_count;
   logic        flush;

   assign flush = flush_drv | ack_flush;

   always #2.5 clk = ~clk;

   cart_cache u0 (
      .clk(clk), .rst_n(rst_n), .base_addr(base_addr), .flush(flush),
      .cart_req(cart_req), .cart_we(cart_we), .cart_addr(cart_addr),
      .cart_wdata(cart_wdata), .cart_rdata(cart_rdata), .cart_rvalid(cart_rvalid),
      .stall(stall), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_wstrb(mem_wstrb), .mem_ack(mem_ack),
      .mem_rdata(mem_rdata), .hit_count(hit_count), .miss_count(miss_count),
      .stall_count(stall_count)
   );

   int nchecks = 0, nfails = 0;
   int exp_hits = 0, exp_misses = 0, exp_stall = 0, txn_count = 0;
   int fixed_lat = -1, lat_left = -1;
   bit ack_flush_en = 0;
   logic [31:0] last_addr;
   logic        last_we;
   logic [7:0]  last_wstrb;
   logic [63:0] last_wdata;
   logic [63:0] ovr [int unsigned];

   bit          ref_v [512];
   logic [10:0] ref_tag [512];
   logic [63:0] ref_line [512];

   task automatic chk(bit ok, string rq, string what, longint act, longint exp);
      nchecks++;
      if (!ok) begin
         nfails++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", rq, what, act, exp);
      end
   endtask

   function automatic logic [63:0] mem_word(logic [31:0] pa);
      if (ovr.exists(pa)) return ovr[pa];
      return {pa * 32'h9E37_79B1, pa ^ 32'hA5A5_5A5A};
   endfunction

   function automatic void ref_clear();
      for (int i = 0; i < 512; i++) ref_v[i] = 0;
   endfunction

   always @(negedge clk) if (rst_n && stall === 1'b1) exp_stall++;

   always @(negedge clk) begin
      if (mem_ack) begin
         mem_ack   = 0;
         ack_flush = 0;
      end else if (rst_n && mem_req) begin
         if (lat_left < 0) lat_left = (fixed_lat >= 0) ? fixed_lat : int'($urandom_range(0, 3));
         if (lat_left == 0) begin
            logic [63:0] w;
            lat_left   = -1;
            last_addr  = mem_addr;
            last_we    = mem_we;
            last_wstrb = mem_wstrb;
            last_wdata = mem_wdata;
            txn_count++;
            w = mem_word(mem_addr);
            if (mem_we) begin
               for (int b = 0; b < 8; b++)
                  if (mem_wstrb[b]) w[8*b +: 8] = mem_wdata[8*b +: 8];
               ovr[mem_addr] = w;
            end
            mem_rdata = w;
            mem_ack   = 1;
            if (ack_flush_en) ack_flush = 1;
         end else begin
            lat_left--;
         end
      end
   end

   task automatic do_op(bit we, logic [22:0] a, logic [7:0] wb, bit fl_with, bit fl_ack,
                        bit fl_mid, bit intrude, string rq);
      logic [8:0]  idx = a[11:3];
      logic [10:0] tg  = a[22:12];
      logic [31:0] pa;
      logic [63:0] w;
      logic [7:0]  eb;
      bit          exp_hit;
      int          t0, n;
      pa = base_addr + {9'd0, a[22:3], 3'b000};
      if (fl_with) ref_clear();
      exp_hit = ref_v[idx] && (ref_tag[idx] == tg);
      t0 = txn_count;
      @(negedge clk);
      cart_req = 1; cart_we = we; cart_addr = a; cart_wdata = wb;
      flush_drv = fl_with; ack_flush_en = fl_ack;
      @(negedge clk);
      cart_req = 0; flush_drv = 0;
      if (!we && exp_hit) begin
         chk(!stall && cart_rvalid, {rq, " R2"}, "hit valid next cycle, no stall",
             {stall, cart_rvalid}, 2'b01);
         eb = ref_line[idx][8*a[2:0] +: 8];
         chk(cart_rdata == eb, {rq, " R2 R4"}, "hit byte", cart_rdata, eb);
         exp_hits++;
      end else if (!we) begin
         chk(stall && !cart_rvalid, {rq, " R3"}, "miss stalls", {stall, cart_rvalid}, 2'b10);
         if (intrude) begin
            cart_req = 1; cart_we = 1; cart_addr = a ^ 23'h40_0000; cart_wdata = 8'hEE;
         end
         if (fl_mid) flush_drv = 1;
         n = 0;
         while (!cart_rvalid && n < 64) begin
            @(negedge clk);
            cart_req = 0; flush_drv = 0;
            n++;
         end
         cart_req = 0; flush_drv = 0;
         w  = mem_word(pa);
         eb = w[8*a[2:0] +: 8];
         chk(cart_rvalid && !stall, {rq, " R3"}, "miss data returned, stall released",
             {stall, cart_rvalid}, 2'b01);
         chk(cart_rdata == eb, {rq, " R3 R4"}, "miss byte lane", cart_rdata, eb);
         chk(last_addr == pa && !last_we, {rq, " R3"}, "fetch address", last_addr, pa);
         if (fl_ack || fl_mid) ref_clear();
         else begin
            ref_v[idx] = 1; ref_tag[idx] = tg; ref_line[idx] = w;
         end
         exp_misses++;
      end else begin
         chk(stall, {rq, " R5"}, "write stalls", stall, 1);
         n = 0;
         while (stall && n < 64) begin
            chk(!cart_rvalid, {rq, " R5"}, "no rvalid on write", cart_rvalid, 0);
            @(negedge clk);
            n++;
         end
         chk(!stall, {rq, " R5"}, "write finishes", stall, 0);
         chk(last_we && last_addr == pa, {rq, " R5"}, "write address", last_addr, pa);
         chk(last_wstrb == (8'h01 << a[2:0]), {rq, " R5"}, "write strobe", last_wstrb,
             8'h01 << a[2:0]);
         chk(last_wdata == {8{wb}}, {rq, " R5"}, "write data lanes", last_wdata, {8{wb}});
         if (exp_hit) ref_line[idx][8*a[2:0] +: 8] = wb;
      end
      chk((txn_count - t0) == ((!we && exp_hit) ? 0 : 1), {rq, " R11"},
          "memory transactions per request", txn_count - t0, (!we && exp_hit) ? 0 : 1);
      ack_flush_en = 0;
   endtask

   initial begin
      #(5.0 * 150000);
      nchecks++; nfails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nchecks, nfails);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      ref_clear();
      repeat (4) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      chk(!stall && !cart_rvalid && !mem_req, "R1", "idle outputs", {stall, cart_rvalid, mem_req}, 0);
      chk(hit_count == 0 && miss_count == 0 && stall_count == 0, "R1", "counters zero",
          hit_count + miss_count + stall_count, 0);

      fixed_lat = 2;
      do_op(0, 23'h00_0013, 0, 0, 0, 0, 0, "R1");      // first access misses
      do_op(0, 23'h00_0013, 0, 0, 0, 0, 0, "R2");      // re-read hits
      do_op(0, 23'h00_0016, 0, 0, 0, 0, 0, "R4");      // other lane, same line
      do_op(0, 23'h00_1010, 0, 0, 0, 0, 0, "R4");      // same index, other tag
      do_op(0, 23'h00_0011, 0, 0, 0, 0, 0, "R4");      // displaced, misses again
      do_op(1, 23'h00_0015, 8'h5C, 0, 0, 0, 0, "R6");  // write hit
      do_op(0, 23'h00_0015, 0, 0, 0, 0, 0, "R6");      // hit with new byte
      do_op(1, 23'h00_2207, 8'hA3, 0, 0, 0, 0, "R6");  // write miss
      do_op(0, 23'h00_2207, 0, 0, 0, 0, 0, "R6");      // no allocation: misses
      do_op(0, 23'h00_2207, 0, 0, 0, 0, 0, "R6");
      @(negedge clk); flush_drv = 1; @(negedge clk); flush_drv = 0;
      ref_clear();
      do_op(0, 23'h00_2207, 0, 0, 0, 0, 0, "R7");      // miss after flush
      do_op(0, 23'h00_2207, 0, 1, 0, 0, 0, "R7");      // flush with request
      do_op(0, 23'h00_2207, 0, 0, 0, 0, 0, "R7");
      @(negedge clk); base_addr = 32'h2000_0000;
      ref_clear();
      do_op(0, 23'h00_2207, 0, 0, 0, 0, 0, "R8");      // new base, misses
      do_op(0, 23'h00_2207, 0, 0, 0, 0, 0, "R8");
      fixed_lat = 0;
      do_op(0, 23'h00_0300, 0, 0, 0, 0, 0, "R3");      // zero-latency fetch
      fixed_lat = 3;
      do_op(0, 23'h00_0400, 0, 0, 1, 0, 0, "R9");      // flush with mem_ack
      do_op(0, 23'h00_0400, 0, 0, 0, 0, 0, "R9");
      do_op(0, 23'h00_0508, 0, 0, 0, 1, 0, "R9");      // flush mid-fetch
      do_op(0, 23'h00_0508, 0, 0, 0, 0, 0, "R9");
      do_op(0, 23'h00_0610, 0, 0, 0, 0, 1, "R11");     // request during stall
      do_op(0, 23'h40_0610, 0, 0, 0, 0, 0, "R11");     // intruding write left no trace
      fixed_lat = -1;

      for (int i = 0; i < 400; i++) begin
         logic [22:0] a;
         bit          we, fw;
         a  = {9'd0, 2'($urandom_range(0, 3)), 4'($urandom_range(0, 15)), 3'($urandom_range(0, 7))};
         a  = {a[22:10], a[9:6], 3'b000, a[2:0]} ;
         a  = {9'd0, a[11:10], 3'b000, a[9:6], a[2:0]} | 23'h0;
         we = ($urandom_range(0, 9) < 3);
         fw = ($urandom_range(0, 19) == 0) && !we;
         do_op(we, a, 8'($urandom), fw, 0, 0, 0, "RND");
      end

      @(negedge clk); @(negedge clk);
      chk(hit_count == exp_hits, "R10", "hit_count", hit_count, exp_hits);
      chk(miss_count == exp_misses, "R10", "miss_count", miss_count, exp_misses);
      chk(stall_count == exp_stall, "R10", "stall_count", stall_count, exp_stall);
      $display("End of test - %0d assertions evaluated, %0d failures", nchecks, nfails);
      $finish;
   end
endmodule